// File: doc/BRIEF.md
# Display Timing Source Mode Controller

This block chooses where the panel timing of a small LCD driver comes from. One source is a free-running frame built from an internal oscillator tick. The other is an external RGB-style interface that supplies an active-low vertical sync, an active-low horizontal sync and a dot clock. Software asks for a source through a two-bit display-mode field and a RAM-access select bit. The block holds that request and makes it active only at a frame boundary, so a frame is never cut short by a mode change.

For the active source, the block produces a frame strobe, a line strobe, the current vertical region (back porch, active or front porch) and the running RAM address. Under external sync the frame length follows the incoming vertical sync. Once the back porch and active lines have passed, the front porch lasts for however long it takes the next vertical sync falling edge to arrive. While the external source is active, the partial-display and scroll enables are forced off and parallel-bus RAM requests are refused. The active source can be read on a status output, so software can poll it rather than wait out a frame blindly.

Top module: `disp_timing_ctrl`

## Requirements
- R1: A mode write with `cfg_dm`=2'b01 and `cfg_rm`=1 requests the external source, and one with `cfg_dm`=2'b00 and `cfg_rm`=0 requests the internal source. Every other combination leaves the pending request unchanged.
- R2: `src_rgb` (1 = external, 0 = internal) takes the pending request only at a frame boundary, which is the edge where `frame_strobe` is high. Outside that edge `src_rgb` holds its value.
- R3: Under the internal source a line is LINE_TICKS `osc_tick` pulses and a frame is BP_LINES+ACT_LINES+FP_LINES lines. `line_strobe` and `frame_strobe` are high for one cycle, one cycle after the tick that ends the line or frame. `region` encodes back porch as 0, active as 1 and front porch as 2.
- R4: Under the external source `osc_tick` has no effect. `frame_strobe` and `line_strobe` follow the falling edges of `vsync_n` and `hsync_n`, and rising `dotclk` edges are the pixel events. Each sync-input effect lands on the third rising clock edge after the input changes.
- R5: At every frame boundary `ram_addr` loads the last value written through `cfg_addr`. Within a frame it increments by one, modulo 2^AW, on each pixel event in the active region, and it changes at no other time.
- R6: Under the external source, `region` is back porch for the first BP_LINES `hsync_n` falls after a `vsync_n` fall and active for the next ACT_LINES falls. It then stays front porch until the next `vsync_n` fall, whatever the number of further lines. After a switch into the external source, `region` is front porch until the first `vsync_n` fall.
- R7: `partial_on` and `scroll_on` follow `cfg_partial` and `cfg_scroll` while `src_rgb`=0, and are 0 while `src_rgb`=1.
- R8: `bus_req` raises `bus_grant` while `src_rgb`=0 and `bus_reject` while `src_rgb`=1. The two outputs are never high together.
- R9: While the internal source is active, activity on `vsync_n`, `hsync_n` and `dotclk` does not change any strobe, region or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_we | input | 1 | Write strobe for the mode field |
| cfg_dm | input | 2 | Display-mode field of the mode write |
| cfg_rm | input | 1 | RAM-access select bit of the mode write |
| cfg_addr_we | input | 1 | Write strobe for the frame start address |
| cfg_addr | input | AW | Frame start address |
| cfg_partial | input | 1 | Partial-display enable requested by software |
| cfg_scroll | input | 1 | Scroll enable requested by software |
| osc_tick | input | 1 | One-cycle tick from the internal oscillator |
| vsync_n | input | 1 | External vertical sync, active low, asynchronous |
| hsync_n | input | 1 | External horizontal sync, active low, asynchronous |
| dotclk | input | 1 | External dot clock, asynchronous |
| bus_req | input | 1 | Parallel-bus RAM access request |
| src_rgb | output | 1 | Active timing source (1 = external) |
| frame_strobe | output | 1 | One-cycle pulse at each frame boundary |
| line_strobe | output | 1 | One-cycle pulse at each line end |
| region | output | 2 | Vertical region: 0 back, 1 active, 2 front porch |
| ram_addr | output | AW | RAM address counter |
| partial_on | output | 1 | Effective partial-display enable |
| scroll_on | output | 1 | Effective scroll enable |
| bus_grant | output | 1 | Bus RAM request accepted |
| bus_reject | output | 1 | Bus RAM request refused |

## Verification
Results driven by `osc_tick` and by configuration writes are due one clock after the edge that samples them. Results driven by a change on `vsync_n`, `hsync_n` or `dotclk` are due on the third rising edge after the change, because the two synchronizer flops and the edge register come first. The gating and bus outputs follow `src_rgb` in the same cycle. The bench drives every input on the falling clock edge and advances its model on the rising edge. It keeps a four-deep history of each sync input to place the edge events, then compares all outputs on the next falling edge, so every check lands in the cycle its result is due.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   typedef enum logic [1:0] {
      RG_BACK   = 2'd0,
      RG_ACTIVE = 2'd1,
      RG_FRONT  = 2'd2
   } region_e;

   typedef enum logic [1:0] {
      REQ_INT  = 2'd0,
      REQ_EXT  = 2'd1,
      REQ_NONE = 2'd2
   } mode_req_e;

   localparam logic [1:0] DM_INTERNAL = 2'b00;
   localparam logic [1:0] DM_EXTSYNC  = 2'b01;

   // R1: only two field combinations form a valid request
   function automatic mode_req_e decode_mode(input logic [1:0] dm, input logic rm);
      if (dm == DM_EXTSYNC && rm)
         return REQ_EXT;
      else if (dm == DM_INTERNAL && !rm)
         return REQ_INT;
      else
         return REQ_NONE;
   endfunction

endpackage

// File: rtl/dtc_sync_edge.sv
module dtc_sync_edge #(
   parameter int STAGES    = 2,
   parameter bit RST_LEVEL = 1'b1,
   parameter bit FALLING   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_p
);

   if (STAGES < 2) begin : g_chk_stages
      $error("dtc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= {STAGES{RST_LEVEL}};
         prev <= RST_LEVEL;
      end else begin
         sh   <= {sh[STAGES-2:0], async_in};
         prev <= sh[STAGES-1];
      end
   end

   if (FALLING) begin : g_fall
      assign edge_p = prev & ~sh[STAGES-1];
   end else begin : g_rise
      assign edge_p = ~prev & sh[STAGES-1];
   end

endmodule

// File: rtl/dtc_int_timer.sv
module dtc_int_timer #(
   parameter int LINE_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic line_end
);

   localparam int TW = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(LINE_TICKS - 1);

   if (LINE_TICKS < 2) begin : g_chk_ticks
      $error("dtc_int_timer: LINE_TICKS must be at least 2");
   end

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tcnt <= '0;
      else if (!run)
         tcnt <= '0;
      else if (tick)
         tcnt <= (tcnt == LAST) ? '0 : tcnt + TW'(1);
   end

   assign line_end = run & tick & (tcnt == LAST);

endmodule

// File: rtl/dtc_line_region.sv
module dtc_line_region
   import dtc_pkg::*;
#(
   parameter int BACK_LINES = 2,
   parameter int ACT_LINES  = 4,
   parameter int LIMIT      = 7,
   parameter int IDLE       = 0,
   parameter int CW         = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       restart,
   input  logic       advance,
   output logic [1:0] region,
   output logic       at_limit
);

   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] IDLE_V = CW'(IDLE);
   localparam logic [CW-1:0] ACT_LO = CW'(BACK_LINES);
   localparam logic [CW-1:0] ACT_HI = CW'(BACK_LINES + ACT_LINES);

   if (LIMIT >= (1 << CW) || IDLE > LIMIT) begin : g_chk_range
      $error("dtc_line_region: LIMIT or IDLE does not fit the counter");
   end

   logic [CW-1:0] lcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lcnt <= IDLE_V;
      else if (clr)
         lcnt <= IDLE_V;
      else if (restart)
         lcnt <= '0;
      else if (advance && lcnt != LIM_V)
         lcnt <= lcnt + CW'(1);
   end

   always_comb begin
      if (lcnt < ACT_LO)
         region = RG_BACK;
      else if (lcnt < ACT_HI)
         region = RG_ACTIVE;
      else
         region = RG_FRONT;
   end

   assign at_limit = (lcnt == LIM_V);

endmodule

// File: rtl/disp_timing_ctrl.sv
module disp_timing_ctrl
   import dtc_pkg::*;
#(
   parameter int AW          = 17,
   parameter int LINE_TICKS  = 4,
   parameter int BP_LINES    = 2,
   parameter int ACT_LINES   = 4,
   parameter int FP_LINES    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mode_we,
   input  logic [1:0]    cfg_dm,
   input  logic          cfg_rm,
   input  logic          cfg_addr_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic          cfg_partial,
   input  logic          cfg_scroll,
   input  logic          osc_tick,
   input  logic          vsync_n,
   input  logic          hsync_n,
   input  logic          dotclk,
   input  logic          bus_req,
   output logic          src_rgb,
   output logic          frame_strobe,
   output logic          line_strobe,
   output logic [1:0]    region,
   output logic [AW-1:0] ram_addr,
   output logic          partial_on,
   output logic          scroll_on,
   output logic          bus_grant,
   output logic          bus_reject
);

   localparam int FRAME_LINES = BP_LINES + ACT_LINES + FP_LINES;
   localparam int LCW         = $clog2(FRAME_LINES + 1);
   localparam int EXT_IDLE    = BP_LINES + ACT_LINES;
   localparam int NSYNC       = 3;
   // bit 0 vertical sync, bit 1 horizontal sync, bit 2 dot clock
   localparam logic [NSYNC-1:0] SYNC_RST  = 3'b011;
   localparam logic [NSYNC-1:0] SYNC_FALL = 3'b011;

   if (AW < 1 || AW > 32) begin : g_chk_aw
      $error("disp_timing_ctrl: AW must lie in 1..32");
   end
   if (BP_LINES < 1 || ACT_LINES < 1 || FP_LINES < 1) begin : g_chk_lines
      $error("disp_timing_ctrl: each vertical region needs at least one line");
   end

   // ---------------- external sync capture (R4) ----------------
   logic [NSYNC-1:0] sync_raw;
   logic [NSYNC-1:0] sync_ev;

   assign sync_raw = {dotclk, hsync_n, vsync_n};

   for (genvar g = 0; g < NSYNC; g++) begin : g_sync
      dtc_sync_edge #(
         .STAGES   (SYNC_STAGES),
         .RST_LEVEL(SYNC_RST[g]),
         .FALLING  (SYNC_FALL[g])
      ) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(sync_raw[g]),
         .edge_p  (sync_ev[g])
      );
   end

   logic vs_fall, hs_fall, dot_rise;
   assign vs_fall  = sync_ev[0];
   assign hs_fall  = sync_ev[1];
   assign dot_rise = sync_ev[2];

   // ---------------- mode state (R1, R2) ----------------
   logic      mode_q;
   logic      req_q;
   mode_req_e wr_req;

   assign wr_req = decode_mode(cfg_dm, cfg_rm);

   // ---------------- internal frame generator (R3) ----------------
   logic       int_line_end;
   logic       int_at_limit;
   logic       int_frame_end;
   logic [1:0] int_region;

   dtc_int_timer #(
      .LINE_TICKS(LINE_TICKS)
   ) u_int_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (~mode_q),
      .tick    (osc_tick),
      .line_end(int_line_end)
   );

   assign int_frame_end = int_line_end & int_at_limit;

   dtc_line_region #(
      .BACK_LINES(BP_LINES),
      .ACT_LINES (ACT_LINES),
      .LIMIT     (FRAME_LINES - 1),
      .IDLE      (0),
      .CW        (LCW)
   ) u_int_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mode_q),
      .restart (int_frame_end),
      .advance (int_line_end),
      .region  (int_region),
      .at_limit(int_at_limit)
   );

   // ---------------- external frame tracker (R6) ----------------
   logic [1:0] ext_region;
   logic       ext_hold;

   dtc_line_region #(
      .BACK_LINES(BP_LINES),
      .ACT_LINES (ACT_LINES),
      .LIMIT     (EXT_IDLE),
      .IDLE      (EXT_IDLE),
      .CW        (LCW)
   ) u_ext_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (~mode_q),
      .restart (vs_fall),
      .advance (hs_fall),
      .region  (ext_region),
      .at_limit(ext_hold)
   );

   // ---------------- source selection ----------------
   logic       boundary;
   logic       line_evt;
   logic       pix_evt;
   logic [1:0] region_cur;

   assign boundary   = mode_q ? vs_fall  : int_frame_end;
   assign line_evt   = mode_q ? hs_fall  : int_line_end;
   assign pix_evt    = mode_q ? dot_rise : osc_tick;
   assign region_cur = mode_q ? (ext_hold ? RG_FRONT : ext_region) : int_region;

   // ---------------- registers ----------------
   logic [AW-1:0] start_q;
   logic [AW-1:0] addr_q;
   logic          fs_q, ls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         mode_q  <= 1'b0;
         start_q <= '0;
         addr_q  <= '0;
         fs_q    <= 1'b0;
         ls_q    <= 1'b0;
      end else begin
         if (cfg_mode_we) begin
            case (wr_req)
               REQ_EXT: req_q <= 1'b1;
               REQ_INT: req_q <= 1'b0;
               default: req_q <= req_q;
            endcase
         end
         if (cfg_addr_we)
            start_q <= cfg_addr;
         if (boundary)
            mode_q <= req_q;
         // R5: reload at frame start, advance on pixels in active lines
         if (boundary)
            addr_q <= start_q;
         else if (pix_evt && region_cur == RG_ACTIVE)
            addr_q <= addr_q + AW'(1);
         fs_q <= boundary;
         ls_q <= line_evt;
      end
   end

   // ---------------- outputs ----------------
   assign src_rgb      = mode_q;
   assign frame_strobe = fs_q;
   assign line_strobe  = ls_q;
   assign region       = region_cur;
   assign ram_addr     = addr_q;
   // R7, R8: features and bus follow the active source
   assign partial_on   = cfg_partial & ~mode_q;
   assign scroll_on    = cfg_scroll & ~mode_q;
   assign bus_grant    = bus_req & ~mode_q;
   assign bus_reject   = bus_req & mode_q;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
   parameter int AW = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          src_rgb,
   input logic          frame_strobe,
   input logic [1:0]    region,
   input logic [AW-1:0] ram_addr,
   input logic          partial_on,
   input logic          scroll_on,
   input logic          bus_grant,
   input logic          bus_reject
);

   // R2
   mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rgb != $past(src_rgb)) |-> frame_strobe);

   // R3
   int_end_in_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && !$past(src_rgb)) |-> ($past(region) == 2'd2));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_strobe && ram_addr != $past(ram_addr))
         |-> (ram_addr == $past(ram_addr) + AW'(1)) && ($past(region) == 2'd1));

   // R6
   porch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rgb && $past(src_rgb) && $past(region) == 2'd2 && !frame_strobe)
         |-> (region == 2'd2));

   // R7
   feature_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_rgb |-> (!partial_on && !scroll_on));

   // R8
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_grant && bus_reject));

   // R8
   bus_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_grant || bus_reject));

endmodule

bind disp_timing_ctrl dtc_checker #(.AW(AW)) u_dtc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_req     (bus_req),
   .src_rgb     (src_rgb),
   .frame_strobe(frame_strobe),
   .region      (region),
   .ram_addr    (ram_addr),
   .partial_on  (partial_on),
   .scroll_on   (scroll_on),
   .bus_grant   (bus_grant),
   .bus_reject  (bus_reject)
);

// File: tb/test_disp_timing_ctrl.sv
module test_disp_timing_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 17;
   localparam int LT  = 4;
   localparam int BP  = 2;
   localparam int ACT = 4;
   localparam int FP  = 2;
   localparam int FL  = BP + ACT + FP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_mode_we = 1'b0;
   logic [1:0]    cfg_dm = 2'b00;
   logic          cfg_rm = 1'b0;
   logic          cfg_addr_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic          cfg_partial = 1'b0;
   logic          cfg_scroll = 1'b0;
   logic          osc_tick = 1'b0;
   logic          vsync_n = 1'b1;
   logic          hsync_n = 1'b1;
   logic          dotclk = 1'b0;
   logic          bus_req = 1'b0;
   logic          src_rgb, frame_strobe, line_strobe;
   logic [1:0]    region;
   logic [AW-1:0] ram_addr;
   logic          partial_on, scroll_on, bus_grant, bus_reject;

   always #(CLK_PERIOD / 2) clk = ~clk;

   disp_timing_ctrl #(
      .AW(AW), .LINE_TICKS(LT), .BP_LINES(BP), .ACT_LINES(ACT), .FP_LINES(FP), .SYNC_STAGES(2)
   ) i_disp_timing_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_mode_we(cfg_mode_we), .cfg_dm(cfg_dm), .cfg_rm(cfg_rm),
      .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr), .cfg_partial(cfg_partial),
      .cfg_scroll(cfg_scroll), .osc_tick(osc_tick), .vsync_n(vsync_n), .hsync_n(hsync_n),
      .dotclk(dotclk), .bus_req(bus_req), .src_rgb(src_rgb), .frame_strobe(frame_strobe),
      .line_strobe(line_strobe), .region(region), .ram_addr(ram_addr), .partial_on(partial_on),
      .scroll_on(scroll_on), .bus_grant(bus_grant), .bus_reject(bus_reject)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    gcyc = 0;
   bit    done = 1'b0;
   string src_tag = "R2";

   // bench model, written from the requirements
   int            m_t = 0, m_li = 0, m_rl = BP + ACT;
   bit            m_mode = 1'b0, m_req = 1'b0;
   logic [AW-1:0] m_addr = '0, m_start = '0;
   logic [3:0]    vh = 4'hF, hh = 4'hF, dh = 4'h0;

   function automatic logic [1:0] region_of(input int l);
      if (l < BP) return 2'd0;
      else if (l < BP + ACT) return 2'd1;
      else return 2'd2;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step();
      bit vf, hf, dr, tick, ile, ife, bnd, lev, pix, old_mode;
      logic [1:0] rpre;
      osc_tick    = (gcyc % 3) != 1;
      bus_req     = (gcyc % 2) == 1;
      cfg_partial = ((gcyc / 2) % 2) == 1;
      cfg_scroll  = ((gcyc / 4) % 2) == 1;
      gcyc++;
      @(posedge clk);
      vh = {vh[2:0], vsync_n};
      hh = {hh[2:0], hsync_n};
      dh = {dh[2:0], dotclk};
      vf = vh[3] & ~vh[2];
      hf = hh[3] & ~hh[2];
      dr = ~dh[3] & dh[2];
      tick = osc_tick;
      old_mode = m_mode;
      ile = !m_mode && tick && (m_t == LT - 1);
      ife = ile && (m_li == FL - 1);
      bnd = m_mode ? vf : ife;
      lev = m_mode ? hf : ile;
      pix = m_mode ? dr : tick;
      rpre = m_mode ? region_of(m_rl) : region_of(m_li);
      if (bnd) m_addr = m_start;
      else if (pix && rpre == 2'd1) m_addr = m_addr + 1'b1;
      if (cfg_addr_we) m_start = cfg_addr;
      if (m_mode) begin
         m_t = 0; m_li = 0;
      end else begin
         if (tick) m_t = (m_t == LT - 1) ? 0 : m_t + 1;
         if (ife) m_li = 0;
         else if (ile) m_li++;
      end
      if (!m_mode) m_rl = BP + ACT;
      else if (vf) m_rl = 0;
      else if (hf && m_rl != BP + ACT) m_rl++;
      if (bnd) m_mode = m_req;
      if (cfg_mode_we) begin
         if (cfg_dm == 2'b01 && cfg_rm) m_req = 1'b1;
         else if (cfg_dm == 2'b00 && !cfg_rm) m_req = 1'b0;
      end
      @(negedge clk);
      chk({src_tag, " src_rgb"}, 32'(src_rgb), 32'(m_mode));
      chk(old_mode ? "R4 frame_strobe" : "R3 R9 frame_strobe", 32'(frame_strobe), 32'(bnd));
      chk(old_mode ? "R4 line_strobe" : "R3 R9 line_strobe", 32'(line_strobe), 32'(lev));
      chk(m_mode ? "R6 region" : "R3 region", 32'(region),
          32'(m_mode ? region_of(m_rl) : region_of(m_li)));
      chk("R5 ram_addr", 32'(ram_addr), 32'(m_addr));
      chk("R7 partial_on", 32'(partial_on), 32'(cfg_partial & !m_mode));
      chk("R7 scroll_on", 32'(scroll_on), 32'(cfg_scroll & !m_mode));
      chk("R8 bus_grant", 32'(bus_grant), 32'(bus_req & !m_mode));
      chk("R8 bus_reject", 32'(bus_reject), 32'(bus_req & m_mode));
      cfg_mode_we = 1'b0;
      cfg_addr_we = 1'b0;
   endtask

   task automatic run_int(input int n, input bit toggle_sync);
      for (int i = 0; i < n; i++) begin
         if (toggle_sync) begin
            vsync_n = (i % 5) != 0;
            hsync_n = (i % 2) == 1;
            dotclk  = ~dotclk;
         end
         step();
      end
   endtask

   task automatic ext_frame(input int lines);
      vsync_n = 1'b0; step(); step();
      vsync_n = 1'b1;
      for (int l = 0; l < lines; l++) begin
         hsync_n = 1'b0; step();
         hsync_n = 1'b1;
         for (int k = 0; k < 6; k++) begin
            dotclk = ~dotclk; step();
         end
      end
   endtask

   task automatic write_mode(input logic [1:0] dm, input logic rm);
      cfg_mode_we = 1'b1; cfg_dm = dm; cfg_rm = rm;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk("R2 reset src_rgb", 32'(src_rgb), 32'd0);
      chk("R3 reset region", 32'(region), 32'd0);
      chk("R3 reset strobes", 32'({frame_strobe, line_strobe}), 32'd0);
      chk("R5 reset ram_addr", 32'(ram_addr), 32'd0);

      // internal frames, start near the top to cover address wrap; sync pins toggled (R9)
      cfg_addr_we = 1'b1; cfg_addr = 17'h1FFFC;
      run_int(130, 1'b1);
      vsync_n = 1'b1; hsync_n = 1'b1;

      // invalid combinations must not request a change (R1)
      src_tag = "R1";
      write_mode(2'b01, 1'b0); step();
      write_mode(2'b10, 1'b1); step();
      write_mode(2'b00, 1'b1); step();
      run_int(90, 1'b0);
      src_tag = "R2";

      // valid request for external source, takes effect at frame end
      write_mode(2'b01, 1'b1);
      run_int(70, 1'b0);
      cfg_addr_we = 1'b1; cfg_addr = 17'h00100;

      // external frames of different lengths: normal, stretched front porch, short
      ext_frame(7);
      ext_frame(13);
      ext_frame(3);
      cfg_addr_we = 1'b1; cfg_addr = 17'h1FFFE;
      ext_frame(8);

      // invalid request while external (R1)
      src_tag = "R1";
      write_mode(2'b00, 1'b1); step();
      ext_frame(6);
      src_tag = "R2";

      // return to internal at the next vertical sync fall
      write_mode(2'b00, 1'b0); step();
      ext_frame(5);
      ext_frame(2);
      run_int(100, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule